// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is a single timer channel that counts down from a programmed start value. It has a register port of its own. A reference-rate strobe is divided by a programmable prescaler, and each divided tick takes one off the count. When the count runs out, the channel raises a sticky status flag. It then either stops (single-shot) or reloads its start value and carries on (repeating). The flag drives a level interrupt only while the interrupt-enable bit is set.

Software reaches the channel through a synchronous 32-bit port. The port has a 2-bit word address, a write strobe, write data and a combinational read-data bus. The four words are:

| Address | Contents |
|---------|----------|
| 0 | control word |
| 1 | start value |
| 2 | live count (read-only) |
| 3 | status (bit 0 only) |

Disabling the channel freezes the count, so counting resumes where it left off. A reload-request bit restarts the count from the start value.

Top module: `dtm_timer_chan`

## Requirements
- R1: After reset the control word reads 0x00000005 (prescaler field 5, every flag clear), the start value and live count read 0, status reads 0, and `irq` is low.
- R2: In the control word, bit 30 is run, bit 29 is interrupt enable, bit 27 is repeat mode, bit 26 is reload request, bit 25 is the busy flag and bits 7:0 are the prescaler. Bits 31, 28 and 24:8 always read 0, so values written to reserved bits are discarded.
- R3: While running, the live count falls by one every (prescaler + 1) cycles in which `ref_tick` is high. No progress is made while `ref_tick` is low. From the enabling write, the run-out event comes after max(start,1)·(prescaler+1) ticks.
- R4: A run-out event sets status bit 0. In repeat mode the count reloads from the start value and the channel keeps running.
- R5: In single-shot mode a run-out event clears both run (bit 30) and busy (bit 25).
- R6: `irq` is high exactly while interrupt enable is set and status bit 0 is set. Toggling interrupt enable alone moves `irq`.
- R7: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R8: A control write with the reload-request bit set loads the live count from the start value and ignores the run bit in the same write. The reload-request bit always reads 0.
- R9: Setting run also sets busy and resumes from the held count. Clearing run clears busy and freezes the live count.
- R10: Clearing run while the live count is 0 is treated as a run-out event.
- R11: Writing the start value reloads the live count at once and restarts the prescaler phase.
- R12: Writes to the busy bit and to the live-count address have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference-rate strobe, one cycle per reference period |
| bus_addr | input | 2 | Word address (0 control, 1 start, 2 live count, 3 status) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker watches several rules on every cycle:
- busy follows run;
- a run-out event always leaves the status flag set;
- a single-shot run-out leaves the channel stopped;
- a write with reload request never leaves the channel running;
- the count holds while the channel is stopped and the port is idle;
- a rising `irq` always has both interrupt enable and status behind it.

Exact tick counts can only be shown by the bench's scenarios. These cover a sweep of prescaler and start values, pause-and-resume, repeat reload, the idle strobe, mid-run start-value rewrites, and the stop-at-zero event. The bench also shows the read-back values after writes to reserved, busy and live-count locations.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int BIT_RUN  = 30;
  localparam int BIT_IEN  = 29;
  localparam int BIT_REP  = 27;
  localparam int BIT_RLD  = 26;
  localparam int BIT_BUSY = 25;

  localparam logic [1:0] ADR_CTL = 2'd0;
  localparam logic [1:0] ADR_INI = 2'd1;
  localparam logic [1:0] ADR_CNT = 2'd2;
  localparam logic [1:0] ADR_STS = 2'd3;

  // run bit requested by a control write; reload request wins over run
  function automatic logic run_request(input logic [31:0] w);
    return w[BIT_RUN] & ~w[BIT_RLD];
  endfunction

  // ticks from enable to run-out for a given start value and prescaler field
  function automatic longint unsigned runout_ticks(input longint unsigned start,
                                                   input longint unsigned pre);
    return ((start == 0) ? 1 : start) * (pre + 1);
  endfunction
endpackage

// File: rtl/dtm_prescaler.sv
module dtm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ref_tick,
  input  logic             restart,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;

  // >= keeps the divider from wrapping when the field shrinks mid-count
  assign tick = run && ref_tick && (phase_q >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)               phase_q <= '0;
    else if (restart || tick) phase_q <= '0;
    else if (run && ref_tick) phase_q <= phase_q + PRE_W'(1);
  end
endmodule

// File: rtl/dtm_downcount.sv
module dtm_downcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             near_zero
);
  assign near_zero = (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (load)                    cnt <= load_val;
    else if (dec && cnt != '0)        cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/dtm_timer_chan.sv
module dtm_timer_chan #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  import dtm_pkg::*;

  localparam logic [PRE_W-1:0] PRE_RST = PRE_W'(5);

  logic             ctl_run, ctl_ien, ctl_rep, ctl_busy;
  logic [PRE_W-1:0] ctl_pre;
  logic [CNT_W-1:0] start_q;
  logic             sts;
  logic [CNT_W-1:0] cnt_q;
  logic             near_zero;

  // named internal events
  logic wr_ctl, wr_ini, wr_sts, port_hold;
  logic run_req, tick, tick_zero, stop_zero, zero_evt, rep_now;
  logic cnt_load;
  logic [CNT_W-1:0] cnt_load_val, cnt_after_rld;

  assign wr_ctl    = bus_wr && (bus_addr == ADR_CTL);
  assign wr_ini    = bus_wr && (bus_addr == ADR_INI);
  assign wr_sts    = bus_wr && (bus_addr == ADR_STS);
  assign port_hold = wr_ctl || wr_ini;
  assign run_req   = run_request(bus_wdata);
  assign rep_now   = wr_ctl ? bus_wdata[BIT_REP] : ctl_rep;

  assign tick_zero     = tick && near_zero;
  assign cnt_after_rld = bus_wdata[BIT_RLD] ? start_q : cnt_q;
  assign stop_zero     = wr_ctl && ctl_run && !run_req && (cnt_after_rld == '0);
  assign zero_evt      = tick_zero || stop_zero;

  assign cnt_load = wr_ini || (wr_ctl && bus_wdata[BIT_RLD]) ||
                    (stop_zero && rep_now) || tick_zero;
  assign cnt_load_val = wr_ini ? bus_wdata[CNT_W-1:0] :
                        (tick_zero && !ctl_rep) ? '0 : start_q;

  dtm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctl_run && !port_hold),
    .ref_tick(ref_tick), .restart(cnt_load), .div(ctl_pre), .tick(tick)
  );

  dtm_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_load_val),
    .dec(tick), .cnt(cnt_q), .near_zero(near_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_run  <= 1'b0;
      ctl_busy <= 1'b0;
      ctl_ien  <= 1'b0;
      ctl_rep  <= 1'b0;
      ctl_pre  <= PRE_RST;
      start_q  <= '0;
      sts      <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctl_run  <= run_req;
        ctl_busy <= run_req;
        ctl_ien  <= bus_wdata[BIT_IEN];
        ctl_rep  <= bus_wdata[BIT_REP];
        ctl_pre  <= bus_wdata[PRE_W-1:0];
      end else if (tick_zero && !ctl_rep) begin
        ctl_run  <= 1'b0;
        ctl_busy <= 1'b0;
      end
      if (wr_ini) start_q <= bus_wdata[CNT_W-1:0];
      if (zero_evt)                     sts <= 1'b1;
      else if (wr_sts && bus_wdata[0])  sts <= 1'b0;
    end
  end

  assign irq = ctl_ien && sts;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADR_CTL: begin
        bus_rdata[BIT_RUN]     = ctl_run;
        bus_rdata[BIT_IEN]     = ctl_ien;
        bus_rdata[BIT_REP]     = ctl_rep;
        bus_rdata[BIT_BUSY]    = ctl_busy;
        bus_rdata[PRE_W-1:0]   = ctl_pre;
      end
      ADR_INI: bus_rdata[CNT_W-1:0] = start_q;
      ADR_CNT: bus_rdata[CNT_W-1:0] = cnt_q;
      default: bus_rdata[0] = sts;
    endcase
  end
endmodule

// File: rtl/dtm_timer_chan_chk.sv
module dtm_timer_chan_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             irq,
  input logic             ctl_run,
  input logic             ctl_busy,
  input logic             ctl_ien,
  input logic             ctl_rep,
  input logic             sts,
  input logic [CNT_W-1:0] cnt_q,
  input logic             tick_zero,
  input logic             zero_evt
);
  AST_BUSY_TRACKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_busy == ctl_run); // R9
  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> sts); // R4
  AST_SINGLE_SHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_zero && !ctl_rep && !bus_wr) |=> (!ctl_run && !ctl_busy)); // R5
  AST_RELOAD_BLOCKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[26]) |=> !ctl_run); // R8
  AST_IDLE_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_run && !bus_wr) |=> $stable(cnt_q)); // R9
  AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ctl_ien && sts)); // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3 && bus_wdata[0] && !zero_evt) |=> !sts); // R7
endmodule

bind dtm_timer_chan dtm_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .ctl_run(ctl_run), .ctl_busy(ctl_busy),
  .ctl_ien(ctl_ien), .ctl_rep(ctl_rep), .sts(sts), .cnt_q(cnt_q),
  .tick_zero(tick_zero), .zero_evt(zero_evt)
);

// File: tb/test_dtm_timer_chan.sv
`timescale 1ns/1ps
module test_dtm_timer_chan;
  localparam logic [31:0] RUN = 32'h4000_0000;
  localparam logic [31:0] IEN = 32'h2000_0000;
  localparam logic [31:0] REP = 32'h0800_0000;
  localparam logic [31:0] RLD = 32'h0400_0000;
  localparam logic [31:0] BSY = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b1;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dtm_timer_chan i_dtm_timer_chan (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_now(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    while (!irq && k < 5000) begin
      @(negedge clk);
      k++;
    end
  endtask

  function automatic int exp_ticks(input int n, input int p);
    return ((n == 0) ? 1 : n) * (p + 1);
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c1, c2;
    int k;
    int nlist[4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_now(2'd0, v); chk("R1 ctl", v, 32'h5);
    rd_now(2'd1, v); chk("R1 start", v, 0);
    rd_now(2'd2, v); chk("R1 count", v, 0);
    rd_now(2'd3, v); chk("R1 sts", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R3 sweep of prescaler and start value, single-shot
    for (int p = 0; p < 4; p++) begin
      for (int j = 0; j < 4; j++) begin
        wr(2'd0, 32'h0);
        wr(2'd3, 32'h1);
        wr(2'd1, nlist[j]);
        wr(2'd0, RUN | IEN | p);
        wait_irq(k);
        chk($sformatf("R3 p=%0d n=%0d ticks", p, nlist[j]), k, exp_ticks(nlist[j], p));
        rd_now(2'd0, v);
        chk("R5 run/busy cleared", v & (RUN | BSY), 0);
      end
    end

    // R4 repeat mode reload
    wr(2'd3, 32'h1);
    wr(2'd1, 3);
    wr(2'd0, RUN | IEN | REP);
    wait_irq(k);
    chk("R4 first period", k, 3);
    rd_now(2'd2, v); chk("R4 reloaded", v, 3);
    rd_now(2'd0, v); chk("R4 still running", v & RUN, RUN);
    wr(2'd3, 32'h1);
    chk("R7 cleared by 1", {31'b0, irq}, 0);
    wait_irq(k);
    chk("R4 next period", k, 1);

    // R6 interrupt gating
    wr(2'd0, 32'h0);
    chk("R6 irq off with ien clear", {31'b0, irq}, 0);
    wr(2'd0, IEN);
    chk("R6 irq on with ien set", {31'b0, irq}, 1);
    wr(2'd3, 32'h0);
    rd_now(2'd3, v); chk("R7 write 0 keeps", v, 1);
    wr(2'd3, 32'h1);
    rd_now(2'd3, v); chk("R7 write 1 clears", v, 0);

    // R8 reload request overrides run
    wr(2'd1, 7);
    wr(2'd0, RUN | RLD);
    rd_now(2'd0, v); chk("R8 ctl after reload", v, 0);
    rd_now(2'd2, v); chk("R8 count reloaded", v, 7);

    // R2 reserved bits, R12 busy and live count read-only
    wr(2'd0, 32'h01FF_FF00 | IEN | REP | 32'hA5);
    rd_now(2'd0, v); chk("R2 reserved dropped", v, 32'h2800_00A5);
    wr(2'd0, BSY);
    rd_now(2'd0, v); chk("R12 busy write ignored", v, 0);
    wr(2'd2, 32'h1234);
    rd_now(2'd2, v); chk("R12 count write ignored", v, 7);

    // R9 pause and resume
    wr(2'd3, 32'h1);
    wr(2'd1, 10);
    wr(2'd0, RUN);
    repeat (3) @(negedge clk);
    wr(2'd0, 32'h0);
    rd_now(2'd2, c1); chk("R3 count after 4 ticks", c1, 6);
    rd_now(2'd0, v);  chk("R9 busy cleared", v & BSY, 0);
    repeat (5) @(negedge clk);
    rd_now(2'd2, c2); chk("R9 frozen", c2, c1);
    wr(2'd0, RUN | IEN);
    rd_now(2'd0, v);  chk("R9 busy set", v & BSY, BSY);
    wait_irq(k);
    chk("R9 resumed remainder", k, 6);

    // R10 stop while count is zero
    wr(2'd3, 32'h1);
    wr(2'd0, 32'h0);
    wr(2'd1, 0);
    wr(2'd0, RUN | 32'hFF);
    wr(2'd0, 32'h0);
    rd_now(2'd3, v); chk("R10 stop at zero flags", v, 1);

    // R11 start write reloads mid-run
    wr(2'd3, 32'h1);
    wr(2'd1, 100);
    wr(2'd0, RUN | IEN);
    repeat (5) @(negedge clk);
    wr(2'd1, 4);
    wait_irq(k);
    chk("R11 reload on start write", k, 4);

    // R3 idle strobe freezes progress
    wr(2'd3, 32'h1);
    ref_tick = 1'b0;
    wr(2'd1, 3);
    wr(2'd0, RUN | IEN);
    repeat (20) @(negedge clk);
    chk("R3 idle strobe irq", {31'b0, irq}, 0);
    rd_now(2'd2, v); chk("R3 idle strobe count", v, 3);
    @(negedge clk);
    ref_tick = 1'b1;
    wait_irq(k);
    chk("R3 strobe resumed", k, 3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule